// File: doc/BRIEF.md
# Bus Target Transaction Length Guard

This block sits beside the target side of a PCI-style bus interface and decides, for every transaction aimed at a slow peripheral, how that transaction ends. It notes the clock on which the frame signal is first seen asserted and counts clocks from there. On the first master-ready of the frame it adds up the frame length the peripheral access would need: the clocks already spent, the fixed offset to the reference cycle, the programmed strobe length, and the final clock. From that sum it either starts the peripheral access or refuses the frame with a retry.

An access that is started is timed by the block. On the clock where the read strobe would be released, the block reports data-phase completion. If the master still holds the frame asserted at that point, it is attempting a burst, and the block marks the same data phase as a disconnect-with-data. After a completed frame the block is idle again at once, so a fast back-to-back frame is accepted with no extra clock.

Top module: `txn_len_guard`

## Requirements
- R1: After reset, and whenever reset is applied, `start_o`, `retry_o`, `done_o` and `disc_o` are all low. The block is idle and waits for a new frame.
- R2: The frame clock index is 0 on the first rising edge where `frame_i` is sampled high while idle. A `mrdy_i` sampled high on that same edge counts as first master-ready at index 0.
- R3: When `mrdy_i` is first sampled high at index m, the predicted frame length is m + REF_OFS + `acc_len_i` + 1. For a read (`is_read_i`=1) whose prediction is at most LIMIT, `start_o` is high for exactly the one cycle after that edge.
- R4: For a read whose prediction exceeds LIMIT, `retry_o` is high for exactly the one cycle after the first master-ready edge, and `start_o` stays low. The two are never high together.
- R5: For a started access, `done_o` is high for exactly the one cycle after the edge REF_OFS + `acc_len_i` edges past the first master-ready edge. It is low at all other times during the access.
- R6: If `frame_i` is sampled high on the completion edge, `disc_o` is high together with `done_o`. The block then ignores the frame until `frame_i` is sampled low. If `frame_i` is low on that edge, `disc_o` stays low.
- R7: After a completion with `frame_i` low, a frame sampled on the very next edge is accepted as a new transaction.
- R8: The frame clock index saturates at 2**IDX_W-1 and does not wrap, so a very late master-ready still yields a retry.
- R9: With GUARD_WR=0, a write (`is_read_i`=0) is always started, whatever its predicted length.
- R10: A retried frame starts no access: `start_o` and `done_o` stay low until the frame ends. A repeated attempt is then judged as a fresh frame.
- R11: Only the first master-ready of a frame counts. Later `mrdy_i` pulses during an access change neither the completion timing nor `start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame asserted (active high) |
| mrdy_i | input | 1 | Master ready asserted (active high) |
| is_read_i | input | 1 | Current transaction is a read |
| acc_len_i | input | LEN_W | Programmed strobe length in clocks after the reference cycle |
| start_o | output | 1 | One-cycle pulse: begin peripheral access |
| retry_o | output | 1 | One-cycle pulse: signal retry for this frame |
| done_o | output | 1 | One-cycle pulse: data phase completes |
| disc_o | output | 1 | With `done_o`: complete as disconnect-with-data |

## Verification
The bench builds the block with its default parameters: LIMIT=16, REF_OFS=2, LEN_W=4 and GUARD_WR=0. With these values the limit sits inside the range of a 4-bit access length. Accepted and retried reads can therefore be placed exactly one clock either side of 16, both at master-ready index 0 and at index 1. A master-ready delayed by 40 clocks drives the 5-bit index into saturation. Long writes show that the write bypass variant is the one built.

// File: rtl/tlg_pkg.sv
package tlg_pkg;
   typedef enum logic [1:0] {
      G_IDLE  = 2'd0,
      G_WAITM = 2'd1,
      G_ACC   = 2'd2,
      G_DRAIN = 2'd3
   } guard_st_e;
endpackage

// File: rtl/tlg_frame_ctr.sv
module tlg_frame_ctr #(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   output logic [IDX_W-1:0] cnt
);
   localparam logic [IDX_W-1:0] CMAX = {IDX_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= {{(IDX_W-1){1'b0}}, 1'b1};
      else if (en && cnt != CMAX)
         cnt <= cnt + 1'b1;
   end

   AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr && cnt == CMAX) |=> (cnt == CMAX)); // R8
endmodule

// File: rtl/tlg_predict.sv
module tlg_predict #(
   parameter int IDX_W    = 5,
   parameter int LEN_W    = 4,
   parameter int REF_OFS  = 2,
   parameter int LIMIT    = 16,
   parameter bit GUARD_WR = 1'b0
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [LEN_W-1:0] len,
   input  logic             is_read,
   output logic             retry_req
);
   localparam int PW = $clog2((2**IDX_W) + (2**LEN_W) + REF_OFS + 2) + 1;

   logic [PW-1:0] pred;
   logic          guard_en;

   always_comb begin
      pred = PW'(idx) + PW'(len) + PW'(REF_OFS + 1);
   end

   generate
      if (GUARD_WR) begin : g_guard_all
         assign guard_en = 1'b1;
      end else begin : g_guard_rd
         assign guard_en = is_read;
      end
   endgenerate

   assign retry_req = guard_en && (pred > PW'(LIMIT));
endmodule

// File: rtl/tlg_acc_timer.sv
module tlg_acc_timer #(
   parameter int LEN_W   = 4,
   parameter int REF_OFS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   output logic             zero
);
   localparam int TW = $clog2((2**LEN_W) + REF_OFS + 1);

   logic [TW-1:0] rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rem <= '0;
      else if (load)
         rem <= TW'(len) + TW'(REF_OFS - 1);
      else if (rem != '0)
         rem <= rem - 1'b1;
   end

   assign zero = (rem == '0);

   AST_TMR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !load) |=> zero); // R5
endmodule

// File: rtl/txn_len_guard.sv
module txn_len_guard #(
   parameter int LIMIT    = 16,
   parameter int REF_OFS  = 2,
   parameter int LEN_W    = 4,
   parameter bit GUARD_WR = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_i,
   input  logic             mrdy_i,
   input  logic             is_read_i,
   input  logic [LEN_W-1:0] acc_len_i,
   output logic             start_o,
   output logic             retry_o,
   output logic             done_o,
   output logic             disc_o
);
   import tlg_pkg::*;

   localparam int IDX_W = $clog2(LIMIT + 1);

   generate
      if (LIMIT < REF_OFS + 2) begin : g_bad_limit
         $error("LIMIT too small for REF_OFS");
      end
      if (REF_OFS < 1) begin : g_bad_ofs
         $error("REF_OFS must be at least 1");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be at least 1");
      end
   endgenerate

   guard_st_e        st;
   logic [IDX_W-1:0] cnt;
   logic [IDX_W-1:0] idx;
   logic             frame_new;
   logic             first_m;
   logic             retry_req;
   logic             tmr_zero;
   logic             tmr_load;

   assign frame_new = (st == G_IDLE) && frame_i;
   assign first_m   = mrdy_i && (frame_new || (st == G_WAITM));
   assign idx       = (st == G_IDLE) ? '0 : cnt;
   assign tmr_load  = first_m && !retry_req;

   tlg_frame_ctr #(.IDX_W(IDX_W)) i_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (frame_new),
      .en    (st == G_WAITM),
      .cnt   (cnt)
   );

   tlg_predict #(
      .IDX_W    (IDX_W),
      .LEN_W    (LEN_W),
      .REF_OFS  (REF_OFS),
      .LIMIT    (LIMIT),
      .GUARD_WR (GUARD_WR)
   ) i_pred (
      .idx       (idx),
      .len       (acc_len_i),
      .is_read   (is_read_i),
      .retry_req (retry_req)
   );

   tlg_acc_timer #(.LEN_W(LEN_W), .REF_OFS(REF_OFS)) i_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .len   (acc_len_i),
      .zero  (tmr_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= G_IDLE;
         start_o <= 1'b0;
         retry_o <= 1'b0;
         done_o  <= 1'b0;
         disc_o  <= 1'b0;
      end else begin
         start_o <= 1'b0;
         retry_o <= 1'b0;
         done_o  <= 1'b0;
         disc_o  <= 1'b0;
         case (st)
            G_IDLE, G_WAITM: begin
               if (first_m) begin
                  if (retry_req) begin
                     retry_o <= 1'b1;
                     st      <= G_DRAIN;
                  end else begin
                     start_o <= 1'b1;
                     st      <= G_ACC;
                  end
               end else if (frame_new) begin
                  st <= G_WAITM;
               end
            end
            G_ACC: begin
               if (tmr_zero) begin
                  done_o <= 1'b1;
                  disc_o <= frame_i;
                  st     <= frame_i ? G_DRAIN : G_IDLE;
               end
            end
            default: begin
               if (!frame_i)
                  st <= G_IDLE;
            end
         endcase
      end
   end

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      !(retry_o && start_o)); // R4
   AST_RETRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      retry_o |=> !retry_o); // R4
   AST_NO_START_AFTER_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
      retry_o |=> !start_o && !done_o); // R10
   AST_DISC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      disc_o |-> done_o); // R6
   AST_START_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> !done_o); // R5
endmodule

// File: tb/test_txn_len_guard.sv
module test_txn_len_guard;
   localparam int LEN_W = 4;
   localparam int LIMIT = 16;
   localparam int REF_OFS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_i = 1'b0;
   logic mrdy_i = 1'b0;
   logic is_read_i = 1'b0;
   logic [LEN_W-1:0] acc_len_i = '0;
   logic start_o, retry_o, done_o, disc_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   txn_len_guard #(.LIMIT(LIMIT), .REF_OFS(REF_OFS), .LEN_W(LEN_W), .GUARD_WR(1'b0))
   i_txn_len_guard (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .mrdy_i(mrdy_i),
      .is_read_i(is_read_i), .acc_len_i(acc_len_i),
      .start_o(start_o), .retry_o(retry_o), .done_o(done_o), .disc_o(disc_o)
   );

   // columns: mrdy index, length, read, hold frame, mrdy noise, idle gap
   localparam int NV = 12;
   localparam int TBL [NV][6] = '{
      '{0, 13, 1, 0, 0, 1},   // R2 R3 exactly at limit
      '{0, 14, 1, 0, 0, 1},   // R4 one over
      '{1, 12, 1, 0, 0, 1},   // R3 R10 after retry
      '{1, 13, 1, 0, 0, 1},   // R4
      '{3, 2, 1, 0, 0, 0},    // R7 next frame back to back
      '{2, 5, 1, 0, 0, 1},    // R7
      '{6, 9, 0, 0, 0, 1},    // R9 long write
      '{2, 3, 1, 1, 0, 2},    // R6 burst
      '{1, 4, 1, 0, 1, 1},    // R11 noise
      '{40, 0, 1, 0, 0, 1},   // R8 saturation
      '{5, 6, 1, 0, 0, 1},    // R10 clean retry attempt
      '{0, 0, 0, 0, 0, 1}     // R5 shortest
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic txn(input int m, input int len, input int rd, input int hold,
                      input int noise, input int gap);
      int exp_r;
      exp_r = (rd != 0 && (m + REF_OFS + 1 + len) > LIMIT) ? 1 : 0;
      frame_i   = 1'b1;
      is_read_i = rd[0];
      acc_len_i = LEN_W'(len);
      mrdy_i    = (m == 0);
      for (int k = 0; k <= m; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k < m) begin
            chk("R2", "no verdict before mrdy", int'(start_o | retry_o), 0);
            mrdy_i = (k + 1 == m);
         end
      end
      chk(exp_r ? "R4" : "R3", "retry_o", int'(retry_o), exp_r);
      chk(exp_r ? "R4" : "R3", "start_o", int'(start_o), 1 - exp_r);
      mrdy_i = noise[0];
      if (exp_r != 0) begin
         frame_i = 1'b0;
         @(posedge clk);
         @(negedge clk);
         chk("R10", "no start after retry", int'(start_o | done_o), 0);
      end else begin
         frame_i = hold[0];
         for (int j = 1; j <= len + REF_OFS; j++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R5", "done_o timing", int'(done_o), (j == len + REF_OFS) ? 1 : 0);
            chk("R11", "single start", int'(start_o | retry_o), 0);
         end
         chk("R6", "disc_o", int'(disc_o), hold);
         frame_i = 1'b0;
         mrdy_i  = 1'b0;
      end
      for (int g = 0; g < gap; g++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R6", "quiet while idle", int'(start_o | retry_o | done_o | disc_o), 0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "outputs in reset", int'({start_o, retry_o, done_o, disc_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "outputs after reset", int'({start_o, retry_o, done_o, disc_o}), 0);

      for (int v = 0; v < NV; v++)
         txn(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3], TBL[v][4], TBL[v][5]);

      // R1: reset in the middle of an access
      frame_i = 1'b1; is_read_i = 1'b1; acc_len_i = 4'd8; mrdy_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1", "start before mid reset", int'(start_o), 1);
      mrdy_i = 1'b0; frame_i = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "outputs during mid reset", int'({start_o, retry_o, done_o, disc_o}), 0);
      rst_n = 1'b1;
      repeat (12) begin
         @(posedge clk);
         @(negedge clk);
         chk("R1", "no done after reset", int'(done_o), 0);
      end
      // R10: retry followed by the repeated attempt, which is accepted
      txn(0, 15, 1, 0, 0, 1);
      txn(0, 5, 1, 0, 0, 1);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule